// File: doc/BRIEF.md
# Differential Phase-Shift Symbol Encoder

This block turns a serial transmit bit stream into a sequence of differential phase states for a baseband modulator. Bits are taken one at a time on clock edges where the data strobe is high and the slot window is open. Each pair of accepted bits forms a two-bit symbol, so the symbol rate is half the bit rate. The symbol selects a phase step that is added to a running phase index, held modulo 8 in units of pi/4.

A mode input chooses between the rotated scheme and plain differential QPSK. In the rotated scheme every step is an odd multiple of pi/4, so the phase visits an 8-point constellation. In plain mode the pi/4 offset is removed, so the step is 0, pi/2, -pi/2 or pi. The phase index is also turned into signed in-phase and quadrature levels for a downstream pulse-shaping filter. A one-clock strobe marks each new symbol.

Top module: `dqpsk_sym_enc`

## Requirements
- R1: After reset the phase index is 0, i_o is +511, q_o is 0 and sym_vld_o is low.
- R2: A bit is accepted only on a rising clock edge where bit_en_i and slot_i are both high; any other bit_i value leaves every output unchanged.
- R3: The first bit accepted after reset, or after any clock edge with slot_i low, is the first symbol bit (Xk) and the next accepted bit is the second (Yk); slot_i low discards a lone pending Xk.
- R4: phase_o changes only on the clock edge that accepts a Yk bit; it holds its value at all other edges.
- R5: With shift_mode_i high, the symbol {Xk,Yk} adds, modulo 8, 1 for 00, 3 for 01, 7 (-1) for 10 and 5 (-3) for 11 to the phase index, so each symbol moves the phase by an odd number of pi/4 steps.
- R6: With shift_mode_i low, the symbol {Xk,Yk} adds, modulo 8, 0 for 00, 2 for 01, 6 (-2) for 10 and 4 for 11.
- R7: i_o and q_o are two's-complement values of 511*cos(k*pi/4) and 511*sin(k*pi/4) for phase index k, rounded toward zero (the diagonal level is 361), and they change together with phase_o.
- R8: sym_vld_o is high for exactly the one clock after each phase update and is never high in two consecutive cycles.
- R9: The step uses the value of shift_mode_i at the edge that accepts Yk, so the mode may change between symbols.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bit_en_i | input | 1 | Data shift strobe; a bit is sampled on edges where it is high |
| slot_i | input | 1 | Slot window; bits are accepted only while high |
| bit_i | input | 1 | Serial transmit bit |
| shift_mode_i | input | 1 | 1 selects the pi/4-rotated scheme, 0 plain differential QPSK |
| phase_o | output | 3 | Running phase index in pi/4 units |
| i_o | output | 10 | Signed in-phase level |
| q_o | output | 10 | Signed quadrature level |
| sym_vld_o | output | 1 | One-clock pulse for each new phase |

## Verification
A wrong pending-bit flag puts Xk and Yk out of step. The next symbol then takes its step from the wrong bit pair, and phase_o is off from the first strobe that follows. A wrong phase update appears on phase_o, i_o and q_o in the very cycle of the strobe. Because the encoding is differential, the error stays in every later phase, so a model that tracks the phase catches it in every cycle after that. A gating fault that lets bits in while the slot is closed moves phase_o or sym_vld_o at the next accepted pair.

// File: rtl/dqpsk_pkg.sv
package dqpsk_pkg;
  localparam int PH_W = 3;
  typedef logic [PH_W-1:0] phase_t;
  typedef logic [1:0]      dibit_t;

  // step in pi/4 units; plain mode removes the pi/4 offset
  function automatic phase_t step_of(dibit_t d, logic shift);
    phase_t s;
    case (d)
      2'b00:   s = phase_t'(1);
      2'b01:   s = phase_t'(3);
      2'b10:   s = phase_t'(7);
      default: s = phase_t'(5);
    endcase
    if (!shift) s = s - phase_t'(1);
    return s;
  endfunction

  function automatic int cos_lvl(phase_t k, int full);
    int diag;
    diag = (full * 181) / 256;
    case (k)
      3'd0:       return full;
      3'd1, 3'd7: return diag;
      3'd3, 3'd5: return -diag;
      3'd4:       return -full;
      default:    return 0;
    endcase
  endfunction
endpackage

// File: rtl/dqpsk_dibit_collect.sv
module dqpsk_dibit_collect
  import dqpsk_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   bit_en_i,
  input  logic   slot_i,
  input  logic   bit_i,
  output dibit_t dibit_o,
  output logic   dibit_vld_o
);
  logic have_x_q, x_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      have_x_q <= 1'b0;
      x_q      <= 1'b0;
    end else if (!slot_i) begin
      have_x_q <= 1'b0;
    end else if (bit_en_i) begin
      if (!have_x_q) x_q <= bit_i;
      have_x_q <= ~have_x_q;
    end
  end

  assign dibit_vld_o = slot_i & bit_en_i & have_x_q;
  assign dibit_o     = {x_q, bit_i};

  a_r3_drop_half: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slot_i |=> !have_x_q);
  a_r2_hold_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_i && !bit_en_i) |=> $stable(have_x_q) && $stable(x_q));
  a_r8_spaced: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dibit_vld_o |=> !dibit_vld_o);
endmodule

// File: rtl/dqpsk_phase_accum.sv
module dqpsk_phase_accum
  import dqpsk_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  dibit_t dibit_i,
  input  logic   dibit_vld_i,
  input  logic   shift_i,
  output phase_t phase_o,
  output logic   sym_vld_o
);
  phase_t phase_q;
  logic   vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      vld_q   <= 1'b0;
    end else begin
      vld_q <= dibit_vld_i;
      if (dibit_vld_i) phase_q <= phase_q + step_of(dibit_i, shift_i);
    end
  end

  assign phase_o   = phase_q;
  assign sym_vld_o = vld_q;

  a_r5_odd_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dibit_vld_i && shift_i) |=> phase_q[0] != $past(phase_q[0]));
  a_r6_even_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dibit_vld_i && !shift_i) |=> phase_q[0] == $past(phase_q[0]));
  a_r4_hold_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dibit_vld_i |=> $stable(phase_q) && !vld_q);
endmodule

// File: rtl/dqpsk_iq_map.sv
module dqpsk_iq_map
  import dqpsk_pkg::*;
#(
  parameter int IQ_W = 10
) (
  input  phase_t                  phase_i,
  output logic signed [IQ_W-1:0]  i_o,
  output logic signed [IQ_W-1:0]  q_o
);
  localparam int FULL = (1 << (IQ_W - 1)) - 1;
  phase_t q_idx;

  // sin(k) = cos(k - 2)
  assign q_idx = phase_i - phase_t'(2);
  assign i_o   = IQ_W'(cos_lvl(phase_i, FULL));
  assign q_o   = IQ_W'(cos_lvl(q_idx, FULL));
endmodule

// File: rtl/dqpsk_sym_enc.sv
module dqpsk_sym_enc
  import dqpsk_pkg::*;
#(
  parameter int IQ_W = 10
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   bit_en_i,
  input  logic                   slot_i,
  input  logic                   bit_i,
  input  logic                   shift_mode_i,
  output logic [PH_W-1:0]        phase_o,
  output logic signed [IQ_W-1:0] i_o,
  output logic signed [IQ_W-1:0] q_o,
  output logic                   sym_vld_o
);
  dibit_t dibit;
  logic   dibit_vld;
  phase_t phase;

  dqpsk_dibit_collect u_collect (
    .clk_i(clk_i), .rst_ni(rst_ni), .bit_en_i(bit_en_i), .slot_i(slot_i),
    .bit_i(bit_i), .dibit_o(dibit), .dibit_vld_o(dibit_vld)
  );

  dqpsk_phase_accum u_accum (
    .clk_i(clk_i), .rst_ni(rst_ni), .dibit_i(dibit), .dibit_vld_i(dibit_vld),
    .shift_i(shift_mode_i), .phase_o(phase), .sym_vld_o(sym_vld_o)
  );

  dqpsk_iq_map #(.IQ_W(IQ_W)) u_map (
    .phase_i(phase), .i_o(i_o), .q_o(q_o)
  );

  assign phase_o = phase;

  a_r7_not_origin: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (i_o != '0) || (q_o != '0));
endmodule

// File: tb/dqpsk_sym_enc_tb.sv
module dqpsk_sym_enc_tb;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic bit_en = 1'b0, slot = 1'b0, bdat = 1'b0, mode = 1'b1;
  logic [2:0] phase;
  logic signed [9:0] iq_i, iq_q;
  logic sym_vld;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  // bench model
  bit m_hx = 0, m_x = 0, m_vld = 0, m_mode_used = 0;
  int m_ph = 0;
  string ctx = "R4";

  always #10 clk = ~clk;

  dqpsk_sym_enc u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .bit_en_i(bit_en), .slot_i(slot),
    .bit_i(bdat), .shift_mode_i(mode), .phase_o(phase), .i_o(iq_i),
    .q_o(iq_q), .sym_vld_o(sym_vld)
  );

  function automatic int lvl_cos(int k);
    case (k % 8)
      0: return 511;
      1, 7: return 361;
      3, 5: return -361;
      4: return -511;
      default: return 0;
    endcase
  endfunction

  function automatic int step_val(bit x, bit y, bit sh);
    int s;
    if (sh) s = (!x && !y) ? 1 : (!x && y) ? 3 : (x && !y) ? 7 : 5;
    else    s = (!x && !y) ? 0 : (!x && y) ? 2 : (x && !y) ? 6 : 4;
    return s;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic check_outputs();
    string ptag;
    ptag = m_vld ? (m_mode_used ? "R5" : "R6") : ctx;
    chk(ptag, int'(phase), m_ph);
    chk("R7 i", int'(iq_i), lvl_cos(m_ph));
    chk("R7 q", int'(iq_q), lvl_cos(m_ph + 6));
    chk("R8", int'(sym_vld), int'(m_vld));
  endtask

  // check current outputs, then drive next inputs and advance the model
  task automatic cyc(bit en, bit sl, bit b, bit md);
    @(negedge clk);
    check_outputs();
    bit_en = en; slot = sl; bdat = b; mode = md;
    m_vld = 0;
    if (!sl) m_hx = 0;
    else if (en) begin
      if (!m_hx) begin m_x = b; m_hx = 1; end
      else begin
        m_ph = (m_ph + step_val(m_x, b, md)) % 8;
        m_mode_used = md; m_hx = 0; m_vld = 1;
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 phase", int'(phase), 0);
    chk("R1 i", int'(iq_i), 511);
    chk("R1 q", int'(iq_q), 0);
    chk("R1 vld", int'(sym_vld), 0);
    rst_ni = 1'b1;

    // R5 each di-bit in rotated mode
    cyc(1,1,0,1); cyc(1,1,0,1);
    cyc(1,1,0,1); cyc(1,1,1,1);
    cyc(1,1,1,1); cyc(1,1,0,1);
    cyc(1,1,1,1); cyc(1,1,1,1);
    // R6 each di-bit in plain mode
    cyc(1,1,0,0); cyc(1,1,0,0);
    cyc(1,1,0,0); cyc(1,1,1,0);
    cyc(1,1,1,0); cyc(1,1,0,0);
    cyc(1,1,1,0); cyc(1,1,1,0);
    // R2: bits with strobe low or slot low are ignored
    ctx = "R2";
    for (int n = 0; n < 6; n++) cyc(0, 1, n[0], 1);
    for (int n = 0; n < 6; n++) cyc(1, 0, ~n[0], 1);
    // R3: lone Xk dropped when slot closes; next bit starts a new pair
    ctx = "R3";
    cyc(1,1,1,1); cyc(0,0,0,1); cyc(1,1,0,1); cyc(1,1,1,1);
    cyc(1,1,1,1); cyc(0,1,0,1); cyc(0,1,1,1); cyc(1,1,0,1);
    // R9: mode switches between Xk and Yk; Yk edge decides
    ctx = "R9";
    cyc(1,1,1,0); cyc(1,1,1,1); cyc(1,1,0,1); cyc(1,1,1,0);
    cyc(0,1,0,1);
    // random
    ctx = "R4";
    void'($urandom(32'h5eed_1234));
    for (int n = 0; n < 4000; n++) begin
      int r = $urandom % 100;
      cyc(($urandom % 3) != 0, r < 92, $urandom % 2,
          (n / 37) % 2 == 0 ? 1'b1 : ($urandom % 8 != 0));
    end
    cyc(0,1,0,1); cyc(0,1,0,1);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule